// File: doc/BRIEF.md
# Safety Error Status Aggregator

This block gathers single-cycle error pulses raised by three protected parts of a network controller: a MAC group (datapath parity, state-machine and interface timeouts, state parity), a queue-memory group (four memories, each reporting correctable, address-mismatch and uncorrectable errors) and a DMA memory group. Each pulse is captured in a sticky 32-bit status word for its group. A read-only summary word separates correctable from uncorrectable conditions, so a handler knows which group to service and how serious the fault is.

Software reaches the block through a plain register port. Writes take effect at the clock edge, and reads return data combinationally from the word address. Status words are cleared by writing ones. Each group has an interrupt enable word, and one combined interrupt output is raised while any enabled status bit is set. A two-bit protection level input decides which error classes may latch at all.

Top module: `safety_err_agg`

## Requirements
- R1: After reset, all three status words and the MAC enable word read 0. The queue-memory enable reads 0x0000_1111 (the correctable bits of its four memories). The DMA enable reads 0x0000_0001. irq_o is 0.
- R2: A pulse on a defined, permitted event bit sets the matching status bit at the next clock edge. The bit then stays set until software clears it.
- R3: Reserved bits never latch and always read 0, in both status and enable words. For MAC these are bits 20-23 and 25-31. For the queue memory they are bits 3, 7, 11, 15 and 16-31. For DMA they are bits 3-31.
- R4: A write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged. Status word addresses are 0 (MAC), 1 (queue memory) and 2 (DMA).
- R5: When an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R6: The protection level input sets which events may latch. At level 0 nothing latches. At level 1 only the queue-memory and DMA events latch. At level 2 the MAC events also latch, except the application-interface parity bits 0 and 5. At level 3 every defined bit latches.
- R7: The summary word is at address 6 and is read-only. Its bits are: bit 0, any MAC status bit set; bit 1, a queue-memory correctable bit (0, 4, 8 or 12) set; bit 2, any other queue-memory status bit set; bit 3, DMA bit 0 set; bit 4, DMA bit 1 or 2 set. All MAC errors count as uncorrectable.
- R8: irq_o is 1 exactly when some group has a status bit set whose enable bit is also set. Enable words are written at addresses 3 (MAC), 4 (queue memory) and 5 (DMA), and they read back from the same addresses.
- R9: Addresses 7 to 15 read 0. A write to addresses 6 to 15 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prot_level_i | input | 2 | Protection level 0..3 |
| mac_evt_i | input | 32 | MAC group error pulses |
| mtl_evt_i | input | 32 | Queue-memory group error pulses |
| dma_evt_i | input | 32 | DMA group error pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Combined safety interrupt |

## Verification
An error pulse and a clearing write can land on the same status word in the same cycle. The bench provokes this by driving the event input and the write strobe on the same falling edge. In one case both target the same bit, and the bit must still read 1 afterwards. In the other case they target different bits of the same word, and only the written bit may drop. The event table also runs every protection level against all-ones event patterns, which checks the latch gating and the reserved-bit masks together.

// File: rtl/safety_err_pkg.sv
package safety_err_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned AW      = 4;
  localparam int unsigned NGRP    = 3;
  localparam int unsigned MEM_CL  = 4;   // memories in the queue group
  localparam int unsigned CL_W    = 4;   // bits per memory cluster

  localparam int unsigned G_MAC = 0;
  localparam int unsigned G_MTL = 1;
  localparam int unsigned G_DMA = 2;

  localparam logic [AW-1:0] A_SUM = AW'(2 * NGRP);

  typedef enum logic [1:0] {PL_OFF, PL_ECC, PL_PAR, PL_EXT} prot_lvl_e;

  localparam logic [DW-1:0] MAC_VALID   = 32'h010F_FFFF;
  localparam logic [DW-1:0] MAC_EXT_PAR = 32'h0000_0021;

  function automatic logic [DW-1:0] corr_mask(int unsigned g);
    logic [DW-1:0] m;
    m = '0;
    if (g == G_MTL) begin
      for (int k = 0; k < int'(MEM_CL); k++) m[k*CL_W] = 1'b1;
    end else if (g == G_DMA) begin
      m[0] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] valid_mask(int unsigned g);
    logic [DW-1:0] m;
    m = '0;
    if (g == G_MAC) begin
      m = MAC_VALID;
    end else if (g == G_MTL) begin
      for (int k = 0; k < int'(MEM_CL); k++)
        for (int b = 0; b < 3; b++) m[k*CL_W+b] = 1'b1;
    end else begin
      m[2:0] = 3'b111;
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] live_mask(int unsigned g, prot_lvl_e lvl);
    logic [DW-1:0] m;
    m = '0;
    if (g == G_MAC) begin
      if (lvl == PL_EXT)      m = MAC_VALID;
      else if (lvl == PL_PAR) m = MAC_VALID & ~MAC_EXT_PAR;
    end else if (lvl != PL_OFF) begin
      m = valid_mask(g);
    end
    return m;
  endfunction
endpackage

// File: rtl/err_group.sv
module err_group
  import safety_err_pkg::*;
#(
  parameter int unsigned  W      = DW,
  parameter logic [W-1:0] VALID  = '1,
  parameter logic [W-1:0] EN_RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] st_o,
  output logic [W-1:0] en_o
);
  logic [W-1:0] st_q, st_d, en_q;

  // set beats clear
  always_comb st_d = (st_q & ~clr_i) | (evt_i & live_i & VALID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      en_q <= EN_RST & VALID;
    end else begin
      st_q <= st_d;
      if (en_we_i) en_q <= en_wdata_i & VALID;
    end
  end

  assign st_o = st_q;
  assign en_o = en_q;
endmodule

// File: rtl/err_summary.sv
module err_summary
  import safety_err_pkg::*;
#(
  parameter int unsigned W = DW,
  parameter int unsigned G = NGRP
) (
  input  logic [G-1:0][W-1:0] st_i,
  input  logic [G-1:0][W-1:0] en_i,
  output logic [W-1:0]        sum_o,
  output logic                irq_o
);
  localparam logic [W-1:0] MTL_CORR = corr_mask(G_MTL);
  localparam logic [W-1:0] DMA_CORR = corr_mask(G_DMA);

  logic [G-1:0] hit;

  for (genvar g = 0; g < int'(G); g++) begin : g_hit
    assign hit[g] = |(st_i[g] & en_i[g]);
  end

  always_comb begin
    sum_o    = '0;
    sum_o[0] = |st_i[G_MAC];
    sum_o[1] = |(st_i[G_MTL] &  MTL_CORR);
    sum_o[2] = |(st_i[G_MTL] & ~MTL_CORR);
    sum_o[3] = |(st_i[G_DMA] &  DMA_CORR);
    sum_o[4] = |(st_i[G_DMA] & ~DMA_CORR);
  end

  assign irq_o = |hit;
endmodule

// File: rtl/err_regif.sv
module err_regif
  import safety_err_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned A  = AW,
  parameter int unsigned G  = NGRP
) (
  input  logic                we_i,
  input  logic [A-1:0]        addr_i,
  input  logic [W-1:0]        wdata_i,
  input  logic [G-1:0][W-1:0] st_i,
  input  logic [G-1:0][W-1:0] en_i,
  input  logic [W-1:0]        sum_i,
  output logic [G-1:0][W-1:0] clr_o,
  output logic [G-1:0]        en_we_o,
  output logic [W-1:0]        rdata_o
);
  localparam logic [A-1:0] SUM_ADDR = A'(2 * G);

  for (genvar g = 0; g < int'(G); g++) begin : g_dec
    assign clr_o[g]   = (we_i && addr_i == A'(g)) ? wdata_i : '0;
    assign en_we_o[g] = we_i && addr_i == A'(G + g);
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < int'(G); g++) begin
      if (addr_i == A'(g))     rdata_o = st_i[g];
      if (addr_i == A'(G + g)) rdata_o = en_i[g];
    end
    if (addr_i == SUM_ADDR) rdata_o = sum_i;
  end
endmodule

// File: rtl/safety_err_agg.sv
module safety_err_agg
  import safety_err_pkg::*;
#(
  parameter int unsigned W = DW,
  parameter int unsigned A = AW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   prot_level_i,
  input  logic [W-1:0] mac_evt_i,
  input  logic [W-1:0] mtl_evt_i,
  input  logic [W-1:0] dma_evt_i,
  input  logic         reg_we_i,
  input  logic [A-1:0] reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         irq_o
);
  localparam int unsigned G = NGRP;

  logic [G-1:0][W-1:0] evt, live, clr, st, en;
  logic [G-1:0]        en_we;
  logic [W-1:0]        sum;
  prot_lvl_e           lvl;

  assign lvl = prot_lvl_e'(prot_level_i);

  assign evt[G_MAC] = mac_evt_i;
  assign evt[G_MTL] = mtl_evt_i;
  assign evt[G_DMA] = dma_evt_i;

  for (genvar g = 0; g < int'(G); g++) begin : g_grp
    assign live[g] = W'(live_mask(g, lvl));
    err_group #(
      .W      (W),
      .VALID  (W'(valid_mask(g))),
      .EN_RST (W'(corr_mask(g)))
    ) grp_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt[g]),
      .live_i     (live[g]),
      .clr_i      (clr[g]),
      .en_we_i    (en_we[g]),
      .en_wdata_i (reg_wdata_i),
      .st_o       (st[g]),
      .en_o       (en[g])
    );
  end

  err_summary #(.W(W), .G(G)) sum_i (
    .st_i  (st),
    .en_i  (en),
    .sum_o (sum),
    .irq_o (irq_o)
  );

  err_regif #(.W(W), .A(A), .G(G)) regif_i (
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .st_i    (st),
    .en_i    (en),
    .sum_i   (sum),
    .clr_o   (clr),
    .en_we_o (en_we),
    .rdata_o (reg_rdata_o)
  );
endmodule

// File: rtl/safety_err_agg_chk.sv
module safety_err_agg_chk
  import safety_err_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             prot_level_i,
  input logic                   reg_we_i,
  input logic [AW-1:0]          reg_addr_i,
  input logic                   irq_o,
  input logic [NGRP-1:0][DW-1:0] evt,
  input logic [NGRP-1:0][DW-1:0] st,
  input logic [NGRP-1:0][DW-1:0] en
);
  for (genvar g = 0; g < int'(NGRP); g++) begin : g_chk
    localparam logic [DW-1:0] VM = valid_mask(g);

    // R3
    p_reserved_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((st[g] | en[g]) & ~VM) == '0);

    // R2
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(reg_we_i && reg_addr_i == AW'(g)) |=> ((st[g] & $past(st[g])) == $past(st[g])));

    // R5, R6: full-level event always lands, even against a clear
    p_event_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prot_level_i == 2'd3) |=> (($past(evt[g]) & VM & ~st[g]) == '0));

    // R6
    p_level_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prot_level_i == 2'd0 && !reg_we_i) |=> $stable(st[g]));
  end

  // R8
  p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(st[G_MAC] & en[G_MAC]) || |(st[G_MTL] & en[G_MTL]) || |(st[G_DMA] & en[G_DMA])));
endmodule

bind safety_err_agg safety_err_agg_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .prot_level_i (prot_level_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .irq_o        (irq_o),
  .evt          (evt),
  .st           (st),
  .en           (en)
);

// File: tb/safety_err_agg_tb_top.sv
module safety_err_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lvl = 2'd0;
  logic [31:0] mac_evt = '0, mtl_evt = '0, dma_evt = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  safety_err_agg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .prot_level_i(lvl),
    .mac_evt_i(mac_evt), .mtl_evt_i(mtl_evt), .dma_evt_i(dma_evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [1:0]  lv;
    logic [31:0] mac, mtl, dma, emac, emtl, edma;
    logic [4:0]  esum;
  } vec_t;

  // R6 R3 R7 table
  localparam vec_t VECS [9] = '{
    '{2'd3, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h010F_FFFF, 32'h0, 32'h0, 5'h01},
    '{2'd2, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h010F_FFDE, 32'h0, 32'h0, 5'h01},
    '{2'd1, 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h0, 32'h1, 32'h0, 5'h02},
    '{2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 5'h00},
    '{2'd1, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h7777, 32'h7, 5'h1E},
    '{2'd3, 32'h0, 32'h66, 32'h0, 32'h0, 32'h66, 32'h0, 5'h04},
    '{2'd1, 32'h0, 32'h0, 32'h4, 32'h0, 32'h0, 32'h4, 5'h10},
    '{2'd2, 32'h0100_0000, 32'h0, 32'h0, 32'h0100_0000, 32'h0, 32'h0, 5'h01},
    '{2'd3, 32'h0, 32'h1000, 32'h1, 32'h0, 32'h1000, 32'h1, 5'h0A}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse(logic [31:0] m, logic [31:0] q, logic [31:0] d);
    @(negedge clk);
    mac_evt = m; mtl_evt = q; dma_evt = d;
    @(negedge clk);
    mac_evt = '0; mtl_evt = '0; dma_evt = '0;
  endtask

  task automatic clear_all();
    for (int g = 0; g < 3; g++) wr(4'(g), 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, exp_irq;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(4'd0, d); chk("R1 mac status", d, 32'h0);
    rd(4'd1, d); chk("R1 mtl status", d, 32'h0);
    rd(4'd2, d); chk("R1 dma status", d, 32'h0);
    rd(4'd3, d); chk("R1 mac enable", d, 32'h0);
    rd(4'd4, d); chk("R1 mtl enable", d, 32'h1111);
    rd(4'd5, d); chk("R1 dma enable", d, 32'h1);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    foreach (VECS[i]) begin
      clear_all();
      lvl = VECS[i].lv;
      pulse(VECS[i].mac, VECS[i].mtl, VECS[i].dma);
      rd(4'd0, d); chk($sformatf("R6 R3 vec%0d mac", i), d, VECS[i].emac);
      rd(4'd1, d); chk($sformatf("R6 R3 vec%0d mtl", i), d, VECS[i].emtl);
      rd(4'd2, d); chk($sformatf("R6 R3 vec%0d dma", i), d, VECS[i].edma);
      rd(4'd6, d); chk($sformatf("R7 vec%0d summary", i), d, {27'b0, VECS[i].esum});
      exp_irq = {31'b0, (|(VECS[i].emtl & 32'h1111)) | VECS[i].edma[0]};
      chk($sformatf("R8 vec%0d irq", i), {31'b0, irq}, exp_irq);
    end

    // R2 sticky, R4 zero-write no effect
    clear_all();
    lvl = 2'd3;
    pulse(32'h0, 32'h0011, 32'h0);
    repeat (3) @(negedge clk);
    rd(4'd1, d); chk("R2 sticky", d, 32'h0011);
    wr(4'd1, 32'h0);
    rd(4'd1, d); chk("R4 zero write keeps", d, 32'h0011);
    wr(4'd1, 32'h0001);
    rd(4'd1, d); chk("R4 partial clear", d, 32'h0010);

    // R5 same bit event and clear
    pulse(32'h0, 32'h0001, 32'h0);
    @(negedge clk);
    we = 1'b1; addr = 4'd1; wdata = 32'h0001; mtl_evt = 32'h0001;
    @(negedge clk);
    we = 1'b0; mtl_evt = '0;
    rd(4'd1, d); chk("R5 event wins same bit", d, 32'h0011);
    // R5 different bits of same word
    @(negedge clk);
    we = 1'b1; addr = 4'd1; wdata = 32'h0010; mtl_evt = 32'h0100;
    @(negedge clk);
    we = 1'b0; mtl_evt = '0;
    rd(4'd1, d); chk("R5 clear other bit", d, 32'h0101);

    // R8 enable and irq
    clear_all();
    rd(4'd0, d);
    chk("R8 irq idle", {31'b0, irq}, 32'h0);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, d); chk("R3 mac enable reserved", d, 32'h010F_FFFF);
    pulse(32'h0000_0100, 32'h0, 32'h0);
    chk("R8 irq mac enabled", {31'b0, irq}, 32'h1);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd4, 32'h0);
    pulse(32'h0, 32'h0001, 32'h0);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(4'd4, 32'h0001);
    chk("R8 irq unmasked", {31'b0, irq}, 32'h1);

    // R9 unused addresses and summary write
    wr(4'd6, 32'hFFFF_FFFF);
    rd(4'd6, d); chk("R9 summary ro", d, 32'h02);
    rd(4'd1, d); chk("R9 status kept", d, 32'h0001);
    for (int a = 7; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd(4'(a), d); chk($sformatf("R9 addr%0d", a), d, 32'h0);
    end
    rd(4'd4, d); chk("R9 enable kept", d, 32'h0001);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule